// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who drives a shared peripheral bus: the chip's internal bus controller or one external bus master. The external master asks for the bus with a hold request. The arbiter answers with a hold acknowledge, and the bus stays with the external master until it withdraws the request. The internal controller reports two things: whether a transfer is waiting, and whether a transfer is running and of which kind (single, burst or cache line). In return it receives a permission signal that says when it may start a transfer, and a burst-terminate strobe.

Each tenure has a priority. A priority pin on the external master chooses between two configured 2-bit levels, and the arbiter samples that choice when the request arrives. It compares the chosen level with the fixed internal priority of 2'b10. A master that ranks above the internal side gets the bus as soon as the running transfer ends, and a running burst is cut short for it. It is never asked to give the bus back early. A master at or below the internal priority waits until the internal side is completely quiet. While it holds the bus, it is asked to give the bus back whenever an internal transfer is waiting. During a tenure, each data beat that the master signals as ready is acknowledged one cycle later.

Top module: `ext_hold_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, holdAck, busReq, burstTerm and extAck are 0 and intAllowed is 1.
- R2: The effective priority is cfgPriLow when holdPri is 0 and cfgPriHigh when holdPri is 1, sampled on the clock edge where the request is first seen. Only the value 2'b11 ranks above the internal level 2'b10; the values 2'b00, 2'b01 and 2'b10 all behave as lower priority.
- R3: With a higher effective priority, holdAck rises after the first clock edge at which holdReq is 1 and intActive is 0, whatever intPending is. busReq stays 0 for the whole tenure.
- R4: With a lower effective priority, holdAck rises only after a clock edge at which holdReq is 1 and both intActive and intPending are 0.
- R5: During a lower-priority tenure, busReq equals intPending while holdAck is 1. busReq is 0 whenever holdAck is 0.
- R6: burstTerm is 1 while a higher-priority request waits and the active transfer is a burst (intKind 2'b01). It stays 0 for single (2'b00) and line (2'b10) transfers, and always stays 0 for a lower-priority request.
- R7: Once holdAck is 1, it stays 1 for as long as holdReq stays 1, whatever the internal inputs do.
- R8: After a clock edge that samples holdReq at 0 while holdAck is 1, holdAck and busReq are 0. intAllowed returns to 1 one cycle after that.
- R9: extAck is 1 in the cycle after a clock edge that samples holdAck, holdReq and extReq all at 1. Otherwise it is 0.
- R10: intAllowed is 0 while holdAck is 1, and 0 while a higher-priority request waits. It stays 1 while a lower-priority request waits.
- R11: If holdReq drops before the grant, the arbiter returns to internal ownership and holdAck never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPriLow | input | 2 | Priority used when holdPri is 0 |
| cfgPriHigh | input | 2 | Priority used when holdPri is 1 |
| intPending | input | 1 | An internal transfer is waiting |
| intActive | input | 1 | An internal transfer is running |
| intKind | input | 2 | Kind of running transfer: 00 single, 01 burst, 10 line |
| intAllowed | output | 1 | The internal controller may start a transfer |
| burstTerm | output | 1 | Request to end the running burst early |
| holdReq | input | 1 | External master requests the bus |
| holdPri | input | 1 | Selects which configured priority applies |
| holdAck | output | 1 | The bus is granted to the external master |
| busReq | output | 1 | Asks the external master to release the bus |
| extReq | input | 1 | External master is ready to move a data beat |
| extAck | output | 1 | A data beat has completed |

## Verification
If the priority is captured wrongly, the ports show it within one or two cycles. The grant comes early (while intPending is 1) or late (held back by pending work). busReq appears, or fails to appear, when intPending rises during a tenure. If the state register fails to leave the waiting state, holdAck stays at 0 after the internal side goes idle. If it fails to leave external ownership, holdAck stays high one cycle too long after holdReq falls. A wrong transfer-kind decode shows up the same cycle as a burstTerm pulse during a line or single transfer.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

  typedef enum logic [1:0] {
    XFER_SINGLE = 2'd0,
    XFER_BURST  = 2'd1,
    XFER_LINE   = 2'd2
  } xferKind_e;

  typedef enum logic [1:0] {
    OWN_INT    = 2'd0,
    WAIT_GRANT = 2'd1,
    OWN_EXT    = 2'd2,
    HAND_BACK  = 2'd3
  } arbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capturePri;  // latch the tenure priority
    logic extPhase;    // external master owns the bus
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic okNow;      // grant condition using the live priority
    logic okHeld;     // grant condition using the latched priority
    logic highNow;    // live priority ranks above internal
    logic highHeld;   // latched priority ranks above internal
  } dpStatus_t;

endpackage

// File: rtl/hold_arb_datapath.sv
module hold_arb_datapath
  import hold_arb_pkg::*;
#(
  parameter int PRI_W = 2,
  parameter logic [PRI_W-1:0] INT_PRI = 2'b10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRI_W-1:0] cfgPriLow,
  input  logic [PRI_W-1:0] cfgPriHigh,
  input  logic             holdPri,
  input  logic             holdReq,
  input  logic             extReq,
  input  logic             intPending,
  input  logic             intActive,
  input  ctlStrobe_t       strobe,
  output dpStatus_t        status,
  output logic             extAck
);

  logic [PRI_W-1:0] selPri;
  logic             highHeldQ;
  logic             intIdle;
  logic             intQuiet;
  logic             extAckQ;

  // pin-selected level, compared against the fixed internal level
  assign selPri   = holdPri ? cfgPriHigh : cfgPriLow;
  assign intIdle  = !intActive;
  assign intQuiet = !intActive && !intPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highHeldQ <= 1'b0;
    end else if (strobe.capturePri) begin
      highHeldQ <= (selPri > INT_PRI);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extAckQ <= 1'b0;
    end else begin
      extAckQ <= strobe.extPhase && holdReq && extReq;
    end
  end

  always_comb begin
    status.highNow  = (selPri > INT_PRI);
    status.highHeld = highHeldQ;
    status.okNow    = status.highNow ? intIdle : intQuiet;
    status.okHeld   = highHeldQ ? intIdle : intQuiet;
  end

  assign extAck = extAckQ;

endmodule

// File: rtl/hold_arb_control.sv
module hold_arb_control
  import hold_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReq,
  input  logic       intPending,
  input  logic       intActive,
  input  xferKind_e  intKind,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       holdAck,
  output logic       busReq,
  output logic       burstTerm,
  output logic       intAllowed
);

  arbState_e stateQ;
  arbState_e stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      OWN_INT: begin
        if (holdReq) begin
          stateNext = status.okNow ? OWN_EXT : WAIT_GRANT;
        end
      end
      WAIT_GRANT: begin
        if (!holdReq) begin
          stateNext = OWN_INT;
        end else if (status.okHeld) begin
          stateNext = OWN_EXT;
        end
      end
      OWN_EXT: begin
        if (!holdReq) begin
          stateNext = HAND_BACK;
        end
      end
      HAND_BACK: begin
        stateNext = OWN_INT;
      end
      default: stateNext = OWN_INT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= OWN_INT;
    end else begin
      stateQ <= stateNext;
    end
  end

  always_comb begin
    strobe.capturePri = (stateQ == OWN_INT) && holdReq;
    strobe.extPhase   = (stateQ == OWN_EXT);
  end

  assign holdAck    = (stateQ == OWN_EXT);
  assign busReq     = (stateQ == OWN_EXT) && !status.highHeld && intPending;
  assign burstTerm  = (stateQ == WAIT_GRANT) && status.highHeld &&
                      intActive && (intKind == XFER_BURST);
  assign intAllowed = (stateQ == OWN_INT) ||
                      ((stateQ == WAIT_GRANT) && !status.highHeld);

endmodule

// File: rtl/ext_hold_arbiter.sv
module ext_hold_arbiter
  import hold_arb_pkg::*;
#(
  parameter int PRI_W = 2,
  parameter logic [PRI_W-1:0] INT_PRI = 2'b10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRI_W-1:0] cfgPriLow,
  input  logic [PRI_W-1:0] cfgPriHigh,
  input  logic             intPending,
  input  logic             intActive,
  input  logic [1:0]       intKind,
  output logic             intAllowed,
  output logic             burstTerm,
  input  logic             holdReq,
  input  logic             holdPri,
  output logic             holdAck,
  output logic             busReq,
  input  logic             extReq,
  output logic             extAck
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  hold_arb_datapath #(.PRI_W(PRI_W), .INT_PRI(INT_PRI)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgPriLow  (cfgPriLow),
    .cfgPriHigh (cfgPriHigh),
    .holdPri    (holdPri),
    .holdReq    (holdReq),
    .extReq     (extReq),
    .intPending (intPending),
    .intActive  (intActive),
    .strobe     (strobe),
    .status     (status),
    .extAck     (extAck)
  );

  hold_arb_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .holdReq    (holdReq),
    .intPending (intPending),
    .intActive  (intActive),
    .intKind    (xferKind_e'(intKind)),
    .status     (status),
    .strobe     (strobe),
    .holdAck    (holdAck),
    .busReq     (busReq),
    .burstTerm  (burstTerm),
    .intAllowed (intAllowed)
  );

endmodule

// File: rtl/ext_hold_arbiter_chk.sv
module ext_hold_arbiter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       intActive,
  input logic [1:0] intKind,
  input logic       intAllowed,
  input logic       burstTerm,
  input logic       holdReq,
  input logic       holdPri,
  input logic       holdAck,
  input logic       busReq,
  input logic       extReq,
  input logic       extAck
);

  // R2
  pri_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdReq && $past(holdReq) |-> $stable(holdPri));

  // R5
  breq_in_tenure_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> holdAck);

  // R6
  term_burst_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstTerm |-> (intActive && intKind == 2'b01 && !holdAck));

  // R7
  ack_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAck && holdReq |=> holdAck);

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAck && !holdReq |=> !holdAck && !busReq);

  // R9
  ext_ack_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(holdAck && holdReq && extReq) |=> !extAck);

  // R10
  owner_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(intAllowed && holdAck));

endmodule

bind ext_hold_arbiter ext_hold_arbiter_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .intActive  (intActive),
  .intKind    (intKind),
  .intAllowed (intAllowed),
  .burstTerm  (burstTerm),
  .holdReq    (holdReq),
  .holdPri    (holdPri),
  .holdAck    (holdAck),
  .busReq     (busReq),
  .extReq     (extReq),
  .extAck     (extAck)
);

// File: tb/ext_hold_arbiter_bench.sv
`timescale 1ns/1ps
module ext_hold_arbiter_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] cfgPriLow, cfgPriHigh;
  logic       intPending, intActive;
  logic [1:0] intKind;
  logic       intAllowed, burstTerm;
  logic       holdReq, holdPri, holdAck, busReq, extReq, extAck;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ext_hold_arbiter u_ext_hold_arbiter (
    .clk(clk), .rstN(rstN), .cfgPriLow(cfgPriLow), .cfgPriHigh(cfgPriHigh),
    .intPending(intPending), .intActive(intActive), .intKind(intKind),
    .intAllowed(intAllowed), .burstTerm(burstTerm), .holdReq(holdReq),
    .holdPri(holdPri), .holdAck(holdAck), .busReq(busReq),
    .extReq(extReq), .extAck(extAck)
  );

  // {holdReq, holdPri, intPending, intActive, intKind[1:0], extReq,
  //  expAck, expBusReq, expBurstTerm, expAllowed, expExtAck}
  // cfgPriLow = 00, cfgPriHigh = 11
  localparam logic [11:0] TBL [0:23] = '{
    12'b1_1_0_1_01_0_0_0_1_0_0, // R6 R10 high waits on burst
    12'b1_1_0_1_01_0_0_0_1_0_0, // R6
    12'b1_1_1_0_00_0_1_0_0_0_0, // R3 grant despite pending
    12'b1_1_1_0_00_1_1_0_0_0_1, // R9 R3
    12'b1_1_1_0_00_0_1_0_0_0_0, // R7
    12'b0_1_1_0_00_0_0_0_0_0_0, // R8 drop
    12'b0_0_0_0_00_0_0_0_0_1_0, // R8 internal back
    12'b1_0_1_0_00_0_0_0_0_1_0, // R4 R10 low waits
    12'b1_0_0_1_01_0_0_0_0_1_0, // R6 no term when low
    12'b1_0_0_1_10_0_0_0_0_1_0, // R4
    12'b1_0_0_0_00_0_1_0_0_0_0, // R4 grant when quiet
    12'b1_0_1_0_00_0_1_1_0_0_0, // R5 reclaim
    12'b1_0_1_0_00_1_1_1_0_0_1, // R5 R9
    12'b1_0_0_0_00_0_1_0_0_0_0, // R5
    12'b0_0_1_0_00_0_0_0_0_0_0, // R8
    12'b0_0_1_0_00_0_0_0_0_1_0, // R8
    12'b1_0_1_0_00_0_0_0_0_1_0, // R11 wait
    12'b0_0_1_0_00_0_0_0_0_1_0, // R11 withdraw
    12'b0_0_0_0_00_0_0_0_0_1_0, // R11
    12'b1_1_0_1_10_0_0_0_0_0_0, // R6 line never cut
    12'b1_1_0_0_00_0_1_0_0_0_0, // R3
    12'b0_1_0_0_00_0_0_0_0_0_0, // R8
    12'b0_0_0_0_00_0_0_0_0_1_0, // R8
    12'b0_0_0_0_00_1_0_0_0_1_0  // R9 no ack without grant
  };

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %b expected %b", req, name, act, exp);
    end
  endtask

  task automatic drive(input logic hr, input logic hp, input logic pe,
                       input logic ac, input logic [1:0] kd, input logic xr);
    holdReq = hr; holdPri = hp; intPending = pe;
    intActive = ac; intKind = kd; extReq = xr;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgPriLow = 2'b00; cfgPriHigh = 2'b11;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    tick(); tick();
    chk("R1", "holdAck in reset", holdAck, 1'b0);
    chk("R1", "intAllowed in reset", intAllowed, 1'b1);
    rstN = 1'b1;
    tick();
    chk("R1", "holdAck", holdAck, 1'b0);
    chk("R1", "busReq", busReq, 1'b0);
    chk("R1", "burstTerm", burstTerm, 1'b0);
    chk("R1", "extAck", extAck, 1'b0);
    chk("R1", "intAllowed", intAllowed, 1'b1);

    for (int i = 0; i < 24; i++) begin
      logic [11:0] v;
      v = TBL[i];
      drive(v[11], v[10], v[9], v[8], v[7:6], v[5]);
      tick();
      chk("vec", $sformatf("row %0d holdAck", i), holdAck, v[4]);
      chk("vec", $sformatf("row %0d busReq", i), busReq, v[3]);
      chk("vec", $sformatf("row %0d burstTerm", i), burstTerm, v[2]);
      chk("vec", $sformatf("row %0d intAllowed", i), intAllowed, v[1]);
      chk("vec", $sformatf("row %0d extAck", i), extAck, v[0]);
    end

    // R2: low field 11 picked by holdPri=0 grants at once despite pending
    cfgPriLow = 2'b11; cfgPriHigh = 2'b10;
    drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
    tick();
    chk("R2", "low field 11 grants", holdAck, 1'b1);
    chk("R2", "no busReq when above", busReq, 1'b0);
    // R7 R3: internal churn during a high tenure
    for (int k = 0; k < 12; k++) begin
      drive(1'b1, 1'b0, k[0], k[1], 2'b01, 1'b0);
      tick();
    end
    chk("R7", "ack held under churn", holdAck, 1'b1);
    chk("R3", "busReq never when above", busReq, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    tick(); tick();
    chk("R8", "allowed after release", intAllowed, 1'b1);

    // R2: high field 10 equals internal level and behaves as lower
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
    tick();
    chk("R2", "level 10 waits on pending", holdAck, 1'b0);
    chk("R2", "level 10 lets internal run", intAllowed, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    tick();
    chk("R4", "grant once quiet", holdAck, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
    #1;
    chk("R5", "level 10 reclaims", busReq, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    tick(); tick();

    // R2: level 01 behaves as lower too
    cfgPriHigh = 2'b01;
    drive(1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0);
    tick();
    chk("R2", "level 01 no burst cut", burstTerm, 1'b0);
    chk("R2", "level 01 no grant while active", holdAck, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    tick();
    chk("R11", "withdrawn, no grant", holdAck, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule